// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges four reset requests into a single internal system reset and decides when that reset may be released. The requests are a power-on flag, an external reset pin (already synchronised to the clock), a watchdog request and a brownout reset request. Any one of them drives the internal reset high at once, with no clock involved. Release is synchronous and comes only after a wake-up timer has run to completion. That timer counts a fixed number of clock edges while the oscillator reports ready. The flash controller must also report that it has finished initialising. When the reset drops, a one-cycle boot-start pulse tells the processor to begin fetching at address zero.

A sticky cause register keeps one bit per source. Bit 0 is the external pin, bit 1 the watchdog, bit 2 power-on and bit 3 brownout. A power-on event wipes the other bits, and software clears bits by writing ones to them.

A separate first-stage brownout warning is synchronised into a status bit. Software can always read that bit. It also raises an interrupt when the interrupt enable is set. The warning never resets the chip; only the second-stage brownout request does that.

The sequencer is a five-state machine:
- **ST_HOLD**: a source is active, or has only just ended.
- **ST_COUNT**: the wake-up timer is running.
- **ST_FLASH**: the count is done and the block waits for the oscillator and flash-ready flags.
- **ST_BOOT**: reset is released and the boot pulse is high.
- **ST_RUN**: normal operation.

The transitions are:
- Any active source forces the machine asynchronously to ST_HOLD.
- ST_HOLD moves to ST_COUNT on the first edge with no source active.
- ST_COUNT moves to ST_FLASH on the edge that completes the count.
- ST_FLASH moves to ST_BOOT on an edge where the oscillator and flash-ready flags are both high.
- ST_BOOT always moves to ST_RUN on the next edge.

Top module: `rst_sequencer`

## Requirements
- R1: While any of por_req, ext_rst_req, wdog_req or bod_rst_req is high, sys_rst is high, and it rises without waiting for a clock edge.
- R2: With osc_ready and flash_done held high, sys_rst falls on the (WAKE_CYCLES+2)-th rising edge after the last source goes low.
- R3: The wake-up timer advances only on edges where osc_ready is high. Each edge with osc_ready low delays release by one edge, and wake_busy stays high during such a pause.
- R4: A source that reasserts while the timer runs restarts the count, so the full WAKE_CYCLES+2 edges are needed after it drops again.
- R5: sys_rst stays high in ST_FLASH for as long as flash_done is low. It falls on the first edge at which flash_done and osc_ready are both high.
- R6: boot_start is high for exactly the one cycle in which sys_rst has just fallen, and low otherwise.
- R7: wake_busy is high exactly while the timer is counting, which is from the edge after sources clear until the count completes.
- R8: Each cause_o bit sets on any edge at which its source is high (bit0 pin, bit1 watchdog, bit2 power-on, bit3 brownout) and then stays set. A bit is cleared only by an edge with cause_clr_we high and the matching cause_clr_mask bit at 1. Mask bits at 0 leave their bits unchanged.
- R9: An edge with por_req high loads cause_o with bit2 set and every other bit equal to its source's current level, discarding older bits.
- R10: warn_status equals bod_warn delayed by SYNC_STAGES edges (default 2), whatever warn_irq_en is. warn_irq is high exactly when warn_status and warn_irq_en are both high. bod_warn has no effect on sys_rst.
- R11: The brownout reset request holds sys_rst high for as long as it stays high, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| por_req | input | 1 | Power-on reset flag, active high |
| ext_rst_req | input | 1 | Synchronised external reset pin, active high |
| wdog_req | input | 1 | Watchdog reset request |
| bod_rst_req | input | 1 | Second-stage brownout reset request |
| osc_ready | input | 1 | Oscillator running flag |
| flash_done | input | 1 | Flash controller initialisation complete |
| bod_warn | input | 1 | First-stage brownout warning, asynchronous |
| warn_irq_en | input | 1 | Interrupt enable for the brownout warning |
| cause_clr_we | input | 1 | Write strobe for clearing cause bits |
| cause_clr_mask | input | 4 | Write-one-to-clear mask for cause bits |
| sys_rst | output | 1 | Internal system reset, active high |
| wake_busy | output | 1 | Wake-up timer counting |
| boot_start | output | 1 | One-cycle pulse when reset is released |
| cause_o | output | 4 | Sticky reset cause bits |
| warn_status | output | 1 | Synchronised brownout warning status |
| warn_irq | output | 1 | Brownout warning interrupt request |

## Verification
If the machine sat in the wrong state, the fault would appear at the ports within one edge of the point where it matters. An early or late fall of sys_rst, measured against the counted release edge, exposes a wrong count or a skipped ST_FLASH wait. A boot_start that is missing or longer than one cycle exposes a wrong ST_BOOT exit. A wake_busy that stays high, or does not rise, on the edge after sources clear points to a wrong ST_HOLD or ST_COUNT transition. Errors in the cause register appear on the edge after the offending write or source pulse.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam int unsigned NUM_SRC   = 4;
    localparam int unsigned CAUSE_PIN = 0;
    localparam int unsigned CAUSE_WDG = 1;
    localparam int unsigned CAUSE_POR = 2;
    localparam int unsigned CAUSE_BOD = 3;

    typedef enum logic [2:0] {
        ST_HOLD  = 3'd0,
        ST_COUNT = 3'd1,
        ST_FLASH = 3'd2,
        ST_BOOT  = 3'd3,
        ST_RUN   = 3'd4
    } seq_state_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

endpackage

// File: rtl/rst_src_combine.sv
module rst_src_combine
    import rst_seq_pkg::*;
(
    input  logic     por_req,
    input  logic     ext_rst_req,
    input  logic     wdog_req,
    input  logic     bod_rst_req,
    output src_vec_t src_vec,
    output logic     any_src
);

    always_comb begin
        src_vec            = '0;
        src_vec[CAUSE_PIN] = ext_rst_req;
        src_vec[CAUSE_WDG] = wdog_req;
        src_vec[CAUSE_POR] = por_req;
        src_vec[CAUSE_BOD] = bod_rst_req;
        any_src            = |src_vec;
    end

endmodule

// File: rtl/rst_wake_timer.sv
module rst_wake_timer #(
    parameter int unsigned WAKE_CYCLES = 4096
) (
    input  logic clk,
    input  logic arst,
    input  logic run,
    input  logic tick,
    output logic done
);

    localparam int unsigned CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && tick && (cnt_q == LAST);

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_seq_pkg::*;
(
    input  logic     clk,
    input  src_vec_t src_vec,
    input  logic     clr_we,
    input  src_vec_t clr_mask,
    output src_vec_t cause
);

    src_vec_t cause_q;
    src_vec_t kept;

    always_comb begin
        kept = clr_we ? (cause_q & ~clr_mask) : cause_q;
    end

    always_ff @(posedge clk) begin
        if (src_vec[CAUSE_POR]) begin
            cause_q <= src_vec;
        end else begin
            cause_q <= kept | src_vec;
        end
    end

    assign cause = cause_q;

endmodule

// File: rtl/rst_bod_warn.sv
module rst_bod_warn #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic warn_in,
    input  logic irq_en,
    output logic status,
    output logic irq
);

    logic [SYNC_STAGES-1:0] sync_q;

    generate
        genvar g;
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk or posedge arst) begin
                if (arst) begin
                    sync_q[g] <= 1'b0;
                end else if (g == 0) begin
                    sync_q[g] <= warn_in;
                end else begin
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign status = sync_q[SYNC_STAGES-1];
    assign irq    = status && irq_en;

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rst_seq_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES = 4096,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                por_req,
    input  logic                ext_rst_req,
    input  logic                wdog_req,
    input  logic                bod_rst_req,
    input  logic                osc_ready,
    input  logic                flash_done,
    input  logic                bod_warn,
    input  logic                warn_irq_en,
    input  logic                cause_clr_we,
    input  logic [NUM_SRC-1:0]  cause_clr_mask,
    output logic                sys_rst,
    output logic                wake_busy,
    output logic                boot_start,
    output logic [NUM_SRC-1:0]  cause_o,
    output logic                warn_status,
    output logic                warn_irq
);

    src_vec_t   src_vec;
    logic       any_src;
    logic       timer_done;
    seq_state_e state_q;
    seq_state_e state_d;

    rst_src_combine u_comb (
        .por_req     (por_req),
        .ext_rst_req (ext_rst_req),
        .wdog_req    (wdog_req),
        .bod_rst_req (bod_rst_req),
        .src_vec     (src_vec),
        .any_src     (any_src)
    );

    rst_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
        .clk  (clk),
        .arst (any_src),
        .run  (state_q == ST_COUNT),
        .tick (osc_ready),
        .done (timer_done)
    );

    rst_cause_reg u_cause (
        .clk      (clk),
        .src_vec  (src_vec),
        .clr_we   (cause_clr_we),
        .clr_mask (cause_clr_mask),
        .cause    (cause_o)
    );

    rst_bod_warn #(.SYNC_STAGES(SYNC_STAGES)) u_warn (
        .clk     (clk),
        .arst    (por_req),
        .warn_in (bod_warn),
        .irq_en  (warn_irq_en),
        .status  (warn_status),
        .irq     (warn_irq)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = ST_COUNT;
            ST_COUNT: if (timer_done) state_d = ST_FLASH;
            ST_FLASH: if (osc_ready && flash_done) state_d = ST_BOOT;
            ST_BOOT:  state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or posedge any_src) begin
        if (any_src) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        sys_rst    = 1'b1;
        wake_busy  = 1'b0;
        boot_start = 1'b0;
        unique case (state_q)
            ST_HOLD:  sys_rst = 1'b1;
            ST_COUNT: wake_busy = 1'b1;
            ST_FLASH: sys_rst = 1'b1;
            ST_BOOT: begin
                sys_rst    = 1'b0;
                boot_start = 1'b1;
            end
            ST_RUN:   sys_rst = 1'b0;
            default:  sys_rst = 1'b1;
        endcase
        if (any_src) begin
            sys_rst    = 1'b1;
            wake_busy  = 1'b0;
            boot_start = 1'b0;
        end
    end

endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk (
    input logic       clk,
    input logic       por_req,
    input logic       ext_rst_req,
    input logic       wdog_req,
    input logic       bod_rst_req,
    input logic       osc_ready,
    input logic       flash_done,
    input logic       warn_irq_en,
    input logic       cause_clr_we,
    input logic [3:0] cause_clr_mask,
    input logic       sys_rst,
    input logic       wake_busy,
    input logic       boot_start,
    input logic [3:0] cause_o,
    input logic       warn_status,
    input logic       warn_irq
);

    a_r1_src_holds_reset: assert property (@(posedge clk) disable iff (por_req)
        (ext_rst_req || wdog_req || bod_rst_req) |-> sys_rst);

    a_r5_release_needs_ready: assert property (@(posedge clk) disable iff (por_req)
        $fell(sys_rst) |-> $past(osc_ready && flash_done));

    a_r6_boot_on_release: assert property (@(posedge clk) disable iff (por_req)
        $fell(sys_rst) |-> boot_start);

    a_r6_boot_single: assert property (@(posedge clk) disable iff (por_req)
        boot_start |=> !boot_start);

    a_r7_busy_in_reset: assert property (@(posedge clk) disable iff (por_req)
        wake_busy |-> sys_rst);

    a_r8_sticky: assert property (@(posedge clk) disable iff (por_req)
        1'b1 |=> (($past(cause_o) & ~($past(cause_clr_we) ? $past(cause_clr_mask) : 4'b0000)
                   & ~cause_o) == 4'b0000));

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (por_req)
        warn_irq |-> (warn_irq_en && warn_status));

endmodule

bind rst_sequencer rst_sequencer_chk chk_i (
    .clk            (clk),
    .por_req        (por_req),
    .ext_rst_req    (ext_rst_req),
    .wdog_req       (wdog_req),
    .bod_rst_req    (bod_rst_req),
    .osc_ready      (osc_ready),
    .flash_done     (flash_done),
    .warn_irq_en    (warn_irq_en),
    .cause_clr_we   (cause_clr_we),
    .cause_clr_mask (cause_clr_mask),
    .sys_rst        (sys_rst),
    .wake_busy      (wake_busy),
    .boot_start     (boot_start),
    .cause_o        (cause_o),
    .warn_status    (warn_status),
    .warn_irq       (warn_irq)
);

// File: tb/rst_sequencer_tb_top.sv
`timescale 1ns/100ps
module rst_sequencer_tb_top;

    localparam int unsigned WAKE = 16;

    logic clk = 1'b0;
    logic por_req = 1'b1, ext_rst_req = 1'b0, wdog_req = 1'b0, bod_rst_req = 1'b0;
    logic osc_ready = 1'b0, flash_done = 1'b0, bod_warn = 1'b0, warn_irq_en = 1'b0;
    logic cause_clr_we = 1'b0;
    logic [3:0] cause_clr_mask = 4'b0000;
    logic sys_rst, wake_busy, boot_start, warn_status, warn_irq;
    logic [3:0] cause_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        int         sel;
        logic [3:0] exp;
        string      req;
    } exp_t;

    exp_t sb_q[$];
    event mon_ev;

    always #2.5 clk = ~clk;

    rst_sequencer #(.WAKE_CYCLES(WAKE)) dut_i (
        .clk(clk), .por_req(por_req), .ext_rst_req(ext_rst_req), .wdog_req(wdog_req),
        .bod_rst_req(bod_rst_req), .osc_ready(osc_ready), .flash_done(flash_done),
        .bod_warn(bod_warn), .warn_irq_en(warn_irq_en), .cause_clr_we(cause_clr_we),
        .cause_clr_mask(cause_clr_mask), .sys_rst(sys_rst), .wake_busy(wake_busy),
        .boot_start(boot_start), .cause_o(cause_o), .warn_status(warn_status),
        .warn_irq(warn_irq)
    );

    function automatic logic [3:0] observe(int sel);
        case (sel)
            0: return {3'b000, sys_rst};
            1: return {3'b000, wake_busy};
            2: return {3'b000, boot_start};
            3: return cause_o;
            4: return {3'b000, warn_status};
            default: return {3'b000, warn_irq};
        endcase
    endfunction

    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                exp_t it;
                logic [3:0] act;
                it = sb_q.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s sel=%0d actual=%b expected=%b", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic push(int sel, logic [3:0] e, string req);
        exp_t it;
        it.sel = sel; it.exp = e; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic flush();
        #0.5;
        -> mon_ev;
        #0.5;
    endtask

    task automatic edges(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        edges(3);
        push(0, 4'b0001, "R1"); push(3, 4'b0100, "R9");
        push(2, 4'b0000, "R6"); push(1, 4'b0000, "R7");
        flush();

        // Power-on release with everything ready.
        por_req = 1'b0; osc_ready = 1'b1; flash_done = 1'b1;
        edges(1);
        push(1, 4'b0001, "R7"); push(0, 4'b0001, "R2"); flush();
        edges(WAKE);
        push(0, 4'b0001, "R2"); push(1, 4'b0000, "R7"); flush();
        edges(1);
        push(0, 4'b0000, "R2"); push(2, 4'b0001, "R6"); flush();
        edges(1);
        push(2, 4'b0000, "R6"); push(0, 4'b0000, "R2"); flush();

        // Watchdog reset, then an oscillator pause.
        wdog_req = 1'b1;
        push(0, 4'b0001, "R1"); flush();
        edges(2);
        push(3, 4'b0110, "R8"); flush();
        wdog_req = 1'b0; osc_ready = 1'b0;
        edges(10);
        push(1, 4'b0001, "R3"); push(0, 4'b0001, "R3"); flush();
        osc_ready = 1'b1;
        edges(WAKE);
        push(0, 4'b0001, "R3"); flush();
        edges(1);
        push(0, 4'b0000, "R3"); push(2, 4'b0001, "R6"); flush();

        // Write-one-to-clear of the watchdog bit.
        cause_clr_we = 1'b1; cause_clr_mask = 4'b0010;
        edges(1);
        cause_clr_we = 1'b0; cause_clr_mask = 4'b0000;
        push(3, 4'b0100, "R8"); flush();
        cause_clr_we = 1'b1; cause_clr_mask = 4'b0000;
        edges(1);
        cause_clr_we = 1'b0;
        push(3, 4'b0100, "R8"); flush();

        // External pin reset reasserted while the timer runs.
        ext_rst_req = 1'b1;
        push(0, 4'b0001, "R1"); flush();
        edges(2);
        ext_rst_req = 1'b0;
        edges(8);
        ext_rst_req = 1'b1;
        edges(1);
        ext_rst_req = 1'b0;
        push(3, 4'b0101, "R8"); flush();
        edges(WAKE + 1);
        push(0, 4'b0001, "R4"); flush();
        edges(1);
        push(0, 4'b0000, "R4"); flush();

        // Brownout reset held, flash not ready.
        bod_rst_req = 1'b1; flash_done = 1'b0;
        edges(5);
        push(0, 4'b0001, "R11"); flush();
        bod_rst_req = 1'b0;
        edges(WAKE + 5);
        push(0, 4'b0001, "R5"); push(1, 4'b0000, "R5"); flush();
        flash_done = 1'b1;
        edges(1);
        push(0, 4'b0000, "R5"); push(2, 4'b0001, "R5"); push(3, 4'b1101, "R8"); flush();

        // Power-on wipes older cause bits.
        por_req = 1'b1;
        edges(2);
        push(3, 4'b0100, "R9"); flush();
        por_req = 1'b0;
        edges(WAKE + 2);
        push(0, 4'b0000, "R2"); flush();

        // First-stage brownout warning.
        warn_irq_en = 1'b0; bod_warn = 1'b1;
        edges(1);
        push(4, 4'b0000, "R10"); flush();
        edges(1);
        push(4, 4'b0001, "R10"); push(5, 4'b0000, "R10"); push(0, 4'b0000, "R10"); flush();
        warn_irq_en = 1'b1;
        push(5, 4'b0001, "R10"); flush();
        bod_warn = 1'b0;
        edges(2);
        push(4, 4'b0000, "R10"); push(5, 4'b0000, "R10"); flush();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule